// File: doc/BRIEF.md
# Fixed Off-Time Peak Current Chopper

This block limits the peak current of a motor bridge one cycle at a time. While the drive is enabled, it waits out a blanking window after every switch-on, so that switching transients on the sense comparator cannot end the on-time early. It then watches the comparator trip flag. When the flag is seen, the block raises a current-limit flag toward the bridge decoder for a fixed number of clock cycles. During that off period a decay selector first asks for fast decay and then for slow decay. When the off period ends, a new drive cycle starts with a fresh blanking window.

A limit-mode input chooses between two behaviours. With the input high, the block chops as described above. With the input low, the block never chops. A trip seen after blanking is instead passed on as a protection request, for a latching shutdown path elsewhere. Dropping the drive enable, or raising the standby input, abandons any timing in progress and parks the block in idle.

All windows are parameters counted in clock cycles. The fast-decay share of the off period is a percentage, and the fast-decay length is the whole-cycle part of that share.

Top module: `chop_regulator`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls with `drive_en` low, `cur_limit`, `fast_decay` and `prot_trip` are all 0.
- R2: After `drive_en` rises from idle, `sense_trip` is ignored for BLANK_CYC+1 clock edges. Counting the enabling edge as edge 1, a trip present only at edges 1 to BLANK_CYC+1 never raises `cur_limit`, and the block does not remember it.
- R3: With `limit_mode`=1, a trip present at edge t raises `cur_limit` at edge max(t, BLANK_CYC+2).
- R4: Each off period keeps `cur_limit` high for exactly OFF_CYC consecutive cycles.
- R5: The off period starts with F = floor(OFF_CYC*FAST_PCT/100) cycles of `fast_decay`=1, followed by OFF_CYC-F cycles of `fast_decay`=0. `fast_decay` is never 1 while `cur_limit` is 0.
- R6: After an off period, a new blanking window starts. With the trip held high, `cur_limit` stays low for exactly BLANK_CYC+1 cycles before the next off period.
- R7: With `limit_mode`=0, `cur_limit` stays 0. `prot_trip` is 1 in each cycle that follows an edge at which a trip is seen after blanking, and is 0 otherwise.
- R8: When `drive_en` is 0 or `standby` is 1 at an edge, all three outputs are 0 after that edge. This holds even on the last cycle of an off period. Re-enabling the block restarts timing from a fresh blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drive_en | input | 1 | Drive enable; low aborts and idles |
| standby | input | 1 | Standby request; high aborts and idles |
| limit_mode | input | 1 | 1 = chop on trip, 0 = forward trip to protection |
| sense_trip | input | 1 | Peak-current comparator flag |
| cur_limit | output | 1 | Off period active, to the bridge decoder |
| fast_decay | output | 1 | Within the off period: 1 = fast decay, 0 = slow decay |
| prot_trip | output | 1 | Trip forwarded to the latching protection path |

## Verification
Two pairs of events can fall in the same cycle. The first is the end of the blanking window and the arrival of a trip. The bench sweeps the trip edge and the pulse position one cycle at a time across the window boundary. It judges the first `cur_limit` edge arithmetically against max(t, BLANK_CYC+2), and checks that a pulse landing on the last blanked edge is lost. The second is an abort arriving on the final slow-decay cycle, just as a new blank would load. The bench checks that idle wins, and that the restart then takes a full blank.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BLANK,
    ST_ON,
    ST_OFF_FAST,
    ST_OFF_SLOW
  } chop_state_e;
endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R2
  hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && expired) |=> expired);
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 8,
  parameter int OFF_CYC   = 20,
  parameter int FAST_CYC  = 3,
  parameter int CW        = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drive_en,
  input  logic          standby,
  input  logic          limit_mode,
  input  logic          sense_trip,
  input  logic          expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          cur_limit,
  output logic          fast_decay,
  output logic          prot_trip
);
  localparam logic [CW-1:0] BLANK_V = CW'(BLANK_CYC - 1);
  localparam logic [CW-1:0] FAST_V  = CW'(FAST_CYC - 1);
  localparam logic [CW-1:0] SLOW_V  = CW'(OFF_CYC - FAST_CYC - 1);
  localparam logic [CW-1:0] OFF_V   = CW'(OFF_CYC);

  chop_state_e st_q, st_d;
  logic        abort;

  assign abort = !drive_en || standby;

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (abort) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_d = ST_BLANK; tmr_load = 1'b1; tmr_val = BLANK_V;
        end
        ST_BLANK:
          if (expired) st_d = ST_ON;
        ST_ON:
          if (sense_trip && limit_mode) begin
            st_d = ST_OFF_FAST; tmr_load = 1'b1; tmr_val = FAST_V;
          end
        ST_OFF_FAST:
          if (expired) begin
            st_d = ST_OFF_SLOW; tmr_load = 1'b1; tmr_val = SLOW_V;
          end
        ST_OFF_SLOW:
          if (expired) begin
            st_d = ST_BLANK; tmr_load = 1'b1; tmr_val = BLANK_V;
          end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cur_limit  <= 1'b0;
      fast_decay <= 1'b0;
      prot_trip  <= 1'b0;
    end else begin
      st_q       <= st_d;
      cur_limit  <= (st_d == ST_OFF_FAST) || (st_d == ST_OFF_SLOW);
      fast_decay <= (st_d == ST_OFF_FAST);
      prot_trip  <= (st_q == ST_ON) && (st_d == ST_ON) && sense_trip && !limit_mode;
    end
  end

  // Run-length tracker for the off-period assertion
  logic [CW-1:0] off_run_q;
  always_ff @(posedge clk) begin
    if (rst)            off_run_q <= '0;
    else if (cur_limit) off_run_q <= off_run_q + 1'b1;
    else                off_run_q <= '0;
  end

  // R4
  off_len_chk: assert property (@(posedge clk) disable iff (rst)
    cur_limit |-> (off_run_q < OFF_V));
  // R5
  fast_in_off_chk: assert property (@(posedge clk) disable iff (rst)
    fast_decay |-> cur_limit);
  // R5
  fast_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cur_limit) |-> fast_decay);
  // R7
  prot_excl_chk: assert property (@(posedge clk) disable iff (rst)
    prot_trip |-> !cur_limit);
  // R8
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (!drive_en || standby) |=> (!cur_limit && !fast_decay && !prot_trip));
endmodule

// File: rtl/chop_regulator.sv
module chop_regulator #(
  parameter int BLANK_CYC = 8,
  parameter int OFF_CYC   = 20,
  parameter int FAST_PCT  = 18
) (
  input  logic clk,
  input  logic rst,
  input  logic drive_en,
  input  logic standby,
  input  logic limit_mode,
  input  logic sense_trip,
  output logic cur_limit,
  output logic fast_decay,
  output logic prot_trip
);
  localparam int FAST_CYC = (OFF_CYC * FAST_PCT) / 100;
  localparam int MAX_CYC  = (BLANK_CYC > OFF_CYC) ? BLANK_CYC : OFF_CYC;
  localparam int CW       = $clog2(MAX_CYC + 2);

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;

  chop_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  chop_fsm #(
    .BLANK_CYC (BLANK_CYC),
    .OFF_CYC   (OFF_CYC),
    .FAST_CYC  (FAST_CYC),
    .CW        (CW)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .drive_en   (drive_en),
    .standby    (standby),
    .limit_mode (limit_mode),
    .sense_trip (sense_trip),
    .expired    (tmr_expired),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .cur_limit  (cur_limit),
    .fast_decay (fast_decay),
    .prot_trip  (prot_trip)
  );
endmodule

// File: tb/tb_chop_regulator.sv
module tb_chop_regulator;
  localparam int CLK_PERIOD = 10;
  localparam int B   = 8;
  localparam int OFF = 20;
  localparam int PCT = 18;
  localparam int F   = (OFF * PCT) / 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, stby = 1'b0, lmode = 1'b1, trip = 1'b0;
  logic cur_limit, fast_decay, prot_trip;
  int   cyc = 0;
  int   checks = 0, fails = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chop_regulator #(.BLANK_CYC(B), .OFF_CYC(OFF), .FAST_PCT(PCT)) dut (
    .clk(clk), .rst(rst), .drive_en(en), .standby(stby), .limit_mode(lmode),
    .sense_trip(trip), .cur_limit(cur_limit), .fast_decay(fast_decay),
    .prot_trip(prot_trip)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    en = 1'b0; trip = 1'b0; stby = 1'b0; lmode = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Enable now; returns edge index of first cur_limit high (-1 if none within 80)
  task automatic wait_rise(int base, output int n);
    n = -1;
    for (int i = 0; i < 80 && n < 0; i++) begin
      @(negedge clk);
      if (cur_limit) n = cyc - base;
    end
  endtask

  initial begin
    int base, n, exp, run, fcnt, fbad, gap, bad;
    repeat (3) @(negedge clk);
    chk(!cur_limit && !fast_decay && !prot_trip, "R1 outputs in reset", cur_limit, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!cur_limit && !fast_decay && !prot_trip, "R1 idle after reset", cur_limit, 0);

    // R3 / R2: sweep trip arrival edge across the blank boundary
    for (int t = 1; t <= B + 4; t++) begin
      go_idle();
      en = 1'b1; base = cyc;
      if (t == 1) trip = 1'b1;
      n = -1;
      for (int i = 0; i < 80 && n < 0; i++) begin
        if (cyc - base == t - 1) trip = 1'b1;
        @(negedge clk);
        if (cur_limit) n = cyc - base;
      end
      exp = (t > B + 2) ? t : B + 2;
      chk(n == exp, "R3 first cur_limit edge", n, exp);
    end

    // R2: single-cycle trip pulse inside the blank window is lost
    for (int t = 1; t <= B + 1; t++) begin
      go_idle();
      en = 1'b1; base = cyc; bad = 0;
      for (int i = 0; i < B + 14; i++) begin
        trip = (cyc - base == t - 1);
        @(negedge clk);
        if (cur_limit) bad++;
      end
      chk(bad == 0, "R2 blanked pulse ignored", bad, 0);
    end

    // R4 R5 R6: trip held, measure off period, decay split and gap
    go_idle();
    en = 1'b1; trip = 1'b1; base = cyc;
    wait_rise(base, n);
    chk(fast_decay == 1'b1, "R5 fast decay first", fast_decay, 1);
    run = 0; fcnt = 0; fbad = 0;
    while (cur_limit && run < 100) begin
      if (fast_decay) begin fcnt++; if (run >= F) fbad++; end
      run++;
      @(negedge clk);
    end
    chk(run == OFF, "R4 off period length", run, OFF);
    chk(fcnt == F && fbad == 0, "R5 fast decay cycles", fcnt, F);
    gap = 0;
    while (!cur_limit && gap < 100) begin
      if (fast_decay) fbad++;
      gap++;
      @(negedge clk);
    end
    chk(gap == B + 1, "R6 reblank gap", gap, B + 1);
    chk(fbad == 0, "R5 fast_decay only in off", fbad, 0);

    // R7: limit_mode low forwards trips
    go_idle();
    lmode = 1'b0; en = 1'b1; trip = 1'b1; base = cyc; bad = 0; run = 0;
    for (int i = 0; i < B + 12; i++) begin
      @(negedge clk);
      if (cur_limit) bad++;
      if (prot_trip != ((cyc - base) >= B + 2)) run++;
    end
    chk(bad == 0, "R7 no chop when limit_mode=0", bad, 0);
    chk(run == 0, "R7 prot_trip timing", run, 0);
    trip = 1'b0;
    @(negedge clk);
    chk(prot_trip == 1'b0, "R7 prot_trip drops with trip", prot_trip, 0);

    // R8: drop enable during fast decay
    go_idle();
    en = 1'b1; trip = 1'b1; base = cyc;
    wait_rise(base, n);
    en = 1'b0;
    @(negedge clk);
    chk(!cur_limit && !fast_decay, "R8 enable abort", cur_limit, 0);

    // R8: abort inside blank window, then fresh blank on re-enable
    go_idle();
    en = 1'b1; base = cyc;
    repeat (4) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1; trip = 1'b1; base = cyc;
    wait_rise(base, n);
    chk(n == B + 2, "R8 restart after blank abort", n, B + 2);

    // R8: standby on the last off cycle, then restart
    go_idle();
    en = 1'b1; trip = 1'b1; base = cyc;
    wait_rise(base, n);
    for (int i = 1; i < OFF; i++) @(negedge clk);
    chk(cur_limit && !fast_decay, "R8 at last slow cycle", cur_limit, 1);
    stby = 1'b1;
    @(negedge clk);
    chk(!cur_limit && !fast_decay && !prot_trip, "R8 standby abort", cur_limit, 0);
    @(negedge clk);
    stby = 1'b0; base = cyc;
    wait_rise(base, n);
    chk(n == B + 2, "R8 restart after standby", n, B + 2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule